// File: doc/BRIEF.md
# Section Trace and A2 Error Inserter

This block sits in the transmit path of a SONET/SDH framer, ahead of the frame-synchronous scrambler. It takes one byte per clock together with that byte's row and column in the frame and a strobe that marks the first byte of each frame. It rewrites a few bytes of the first overhead row and passes every other byte through with one register of latency.

The section trace byte (J0) is filled from a 16-byte sequence held in registers, one entry per frame, in repeating order. The two growth bytes that follow J0 take two programmed values. When trace or growth insertion is switched off, those bytes take a global default fill of all zeros or all ones. All three bytes are flagged on a side output so that the scrambler leaves them alone.

For framer test, a single start pulse makes a programmed run of 1 to 32 consecutive frames carry the first A2 framing byte inverted. A normal 0x28 therefore leaves as 0xD7.

Top module: `sec_trace_a2_ins`

## Requirements
- R1: With `j0_en_i` high, the output byte for the J0 position (row 0, column 2·NUM_STS) is trace entry k, taken from `trace_i[8k+7:8k]`, where k counts the J0 bytes inserted since insertion was last enabled.
- R2: With `j0_en_i` low, the J0 output byte is 0x00 when `fill_ones_i` is 0 and 0xFF when it is 1.
- R3: After trace entry 15 has been used, the next J0 byte uses entry 0.
- R4: Any J0 position passed while `j0_en_i` is low sets the trace position back to 0, so the first J0 byte after re-enabling uses entry 0.
- R5: With `z0_en_i` high, the output bytes at row 0, columns 2·NUM_STS+1 and 2·NUM_STS+2 are `z0_2_i` and `z0_3_i`, in that order.
- R6: With `z0_en_i` low, both of those bytes are 0x00 or 0xFF according to `fill_ones_i`.
- R7: `no_scr_o` is high together with exactly those output bytes that came from the J0 or the two Z0 positions.
- R8: A pulse on `a2_err_start_i` starts a run at the next `frame_start_i` that follows the pulse cycle. For `a2_err_cnt_i`+1 consecutive frames, the byte at row 0, column NUM_STS (A2-1) leaves bitwise inverted. The count value is captured with the pulse, so 0 gives one frame and 31 gives 32 frames.
- R9: A start pulse that arrives while a run is pending or in progress is ignored. Neither the run length nor the new count has any effect.
- R10: Every other byte, including A2-2, A1 and all bytes outside row 0, appears on `data_o` unchanged one clock after it arrives. During reset, `data_o` and `no_scr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Byte clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Incoming frame byte |
| row_i | input | ROW_W | Row of `data_i`, 0 is the first row |
| col_i | input | COL_W | Column of `data_i`, 0 is the first A1 byte |
| frame_start_i | input | 1 | High on the first byte of each frame |
| j0_en_i | input | 1 | Trace insertion enable |
| z0_en_i | input | 1 | Growth byte insertion enable |
| fill_ones_i | input | 1 | Default fill: 0 gives 0x00, 1 gives 0xFF |
| trace_i | input | 8·TRACE_LEN | Trace sequence, entry k in bits 8k+7:8k |
| z0_2_i | input | 8 | Value for the first byte after J0 |
| z0_3_i | input | 8 | Value for the second byte after J0 |
| a2_err_cnt_i | input | CNT_W | Run length minus one |
| a2_err_start_i | input | 1 | One-cycle pulse that starts an A2 error run |
| data_o | output | 8 | Outgoing byte, one cycle after `data_i` |
| no_scr_o | output | 1 | Marks `data_o` as a byte the scrambler must skip |

## Verification
The bench walks the trace index through a disable that must clear it, through a full wrap past entry 15, and through the first frame after re-enabling. A design that only held the index, or that advanced it per byte rather than per frame, would show the wrong trace entry. The A2 runs are measured at the shortest length, a middle length and the full 32 frames, with a second pulse and a new count given mid-run. An off-by-one in the count, a run that starts inside the pulse's own frame, or a restart caused by the late pulse would show up as one inverted frame too many or too few. Every byte of each frame is compared, so a design that disturbed A2-2 or flagged the wrong bytes as unscrambled would also fail.

// File: rtl/sec_ovh_pkg.sv
package sec_ovh_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // Position classes that the inserter treats specially
  typedef enum logic [2:0] {
    POS_OTHER = 3'd0,
    POS_A2_1  = 3'd1,
    POS_J0    = 3'd2,
    POS_Z0_2  = 3'd3,
    POS_Z0_3  = 3'd4
  } pos_e;
endpackage

// File: rtl/sec_pos_decode.sv
module sec_pos_decode
  import sec_ovh_pkg::*;
#(
  parameter int NUM_STS = 3,
  parameter int ROW_W   = 4,
  parameter int COL_W   = 12
) (
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  output pos_e             pos_o
);
  localparam int A2_1_COL = NUM_STS;
  localparam int J0_COL   = 2 * NUM_STS;
  localparam int Z02_COL  = J0_COL + 1;
  localparam int Z03_COL  = J0_COL + 2;

  always_comb begin
    pos_o = POS_OTHER;
    if (row_i == '0) begin
      if (col_i == COL_W'(A2_1_COL))     pos_o = POS_A2_1;
      else if (col_i == COL_W'(J0_COL))  pos_o = POS_J0;
      else if (col_i == COL_W'(Z02_COL)) pos_o = POS_Z0_2;
      else if (col_i == COL_W'(Z03_COL)) pos_o = POS_Z0_3;
    end
  end
endmodule

// File: rtl/sec_trace_seq.sv
module sec_trace_seq
  import sec_ovh_pkg::*;
#(
  parameter int TRACE_LEN = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        en_i,
  input  logic                        hit_i,
  input  logic [TRACE_LEN*BYTE_W-1:0] trace_i,
  output byte_t                       byte_o
);
  localparam int IDX_W = (TRACE_LEN > 1) ? $clog2(TRACE_LEN) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(TRACE_LEN - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          idx_q <= '0;
    else if (!en_i)       idx_q <= '0;
    else if (hit_i)       idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
  end

  assign byte_o = trace_i[idx_q*BYTE_W +: BYTE_W];

  a_r3_idx_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && hit_i && idx_q == LAST) |=> (idx_q == '0));
  a_r4_idx_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i) |=> (idx_q == '0));
  a_r1_idx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !hit_i) |=> $stable(idx_q));
endmodule

// File: rtl/sec_a2_err_ctrl.sv
module sec_a2_err_ctrl #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             active_o
);
  logic             pending_q, active_q;
  logic [CNT_W-1:0] cnt_q, rem_q;
  logic             idle;

  assign idle = !pending_q && !active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      active_q  <= 1'b0;
      cnt_q     <= '0;
      rem_q     <= '0;
    end else begin
      // Arm only from idle; run starts at the following frame boundary
      if (start_i && idle) begin
        pending_q <= 1'b1;
        cnt_q     <= cnt_i;
      end
      if (frame_start_i) begin
        if (pending_q) begin
          pending_q <= 1'b0;
          active_q  <= 1'b1;
          rem_q     <= cnt_q;
        end else if (active_q) begin
          if (rem_q == '0) active_q <= 1'b0;
          else             rem_q    <= rem_q - 1'b1;
        end
      end
    end
  end

  assign active_o = active_q;

  a_r9_busy_ignores_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle && start_i) |=> $stable(cnt_q));
  a_r8_rem_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (rem_q <= cnt_q));
  a_r8_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pending_q && active_q));
  a_r8_mid_frame_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_start_i) |=> $stable(active_q));
endmodule

// File: rtl/sec_trace_a2_ins.sv
module sec_trace_a2_ins
  import sec_ovh_pkg::*;
#(
  parameter int NUM_STS   = 3,
  parameter int ROW_W     = 4,
  parameter int COL_W     = 12,
  parameter int TRACE_LEN = 16,
  parameter int CNT_W     = 5
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [7:0]                  data_i,
  input  logic [ROW_W-1:0]            row_i,
  input  logic [COL_W-1:0]            col_i,
  input  logic                        frame_start_i,
  input  logic                        j0_en_i,
  input  logic                        z0_en_i,
  input  logic                        fill_ones_i,
  input  logic [TRACE_LEN*8-1:0]      trace_i,
  input  logic [7:0]                  z0_2_i,
  input  logic [7:0]                  z0_3_i,
  input  logic [CNT_W-1:0]            a2_err_cnt_i,
  input  logic                        a2_err_start_i,
  output logic [7:0]                  data_o,
  output logic                        no_scr_o
);
  pos_e  pos;
  byte_t trace_byte, fill_byte, data_d;
  logic  a2_active, no_scr_d;

  sec_pos_decode #(
    .NUM_STS(NUM_STS), .ROW_W(ROW_W), .COL_W(COL_W)
  ) u_pos (
    .row_i (row_i),
    .col_i (col_i),
    .pos_o (pos)
  );

  sec_trace_seq #(.TRACE_LEN(TRACE_LEN)) u_trace (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (j0_en_i),
    .hit_i   (pos == POS_J0),
    .trace_i (trace_i),
    .byte_o  (trace_byte)
  );

  sec_a2_err_ctrl #(.CNT_W(CNT_W)) u_a2 (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start_i),
    .start_i       (a2_err_start_i),
    .cnt_i         (a2_err_cnt_i),
    .active_o      (a2_active)
  );

  assign fill_byte = {BYTE_W{fill_ones_i}};

  always_comb begin
    data_d   = data_i;
    no_scr_d = 1'b0;
    unique case (pos)
      POS_A2_1: data_d = a2_active ? ~data_i : data_i;
      POS_J0: begin
        data_d   = j0_en_i ? trace_byte : fill_byte;
        no_scr_d = 1'b1;
      end
      POS_Z0_2: begin
        data_d   = z0_en_i ? z0_2_i : fill_byte;
        no_scr_d = 1'b1;
      end
      POS_Z0_3: begin
        data_d   = z0_en_i ? z0_3_i : fill_byte;
        no_scr_d = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o   <= '0;
      no_scr_o <= 1'b0;
    end else begin
      data_o   <= data_d;
      no_scr_o <= no_scr_d;
    end
  end

  a_r10_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos == POS_OTHER) |=> (data_o == $past(data_i)));
  a_r7_flag_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos == POS_OTHER || pos == POS_A2_1) |=> !no_scr_o);
  a_r2_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos == POS_J0 && !j0_en_i) |=> (data_o == {8{$past(fill_ones_i)}}));
  a_r6_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos == POS_Z0_3 && !z0_en_i) |=> (data_o == {8{$past(fill_ones_i)}}));
endmodule

// File: tb/sec_trace_a2_ins_tb_top.sv
`timescale 1ns/1ps
module sec_trace_a2_ins_tb_top;
  localparam int NUM_STS = 3;
  localparam int ROW_W   = 4;
  localparam int COL_W   = 12;
  localparam int TL      = 16;
  localparam int CNT_W   = 5;
  localparam int FCOLS   = 12;
  localparam int FROWS   = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] data_i = '0;
  logic [ROW_W-1:0] row_i = '0;
  logic [COL_W-1:0] col_i = '0;
  logic frame_start_i = 1'b0;
  logic j0_en_i = 1'b0, z0_en_i = 1'b0, fill_ones_i = 1'b0;
  logic [TL*8-1:0] trace_i;
  logic [7:0] z0_2_i = 8'h5A, z0_3_i = 8'hC3;
  logic [CNT_W-1:0] a2_err_cnt_i = '0;
  logic a2_err_start_i = 1'b0;
  logic [7:0] data_o;
  logic no_scr_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  sec_trace_a2_ins #(
    .NUM_STS(NUM_STS), .ROW_W(ROW_W), .COL_W(COL_W), .TRACE_LEN(TL), .CNT_W(CNT_W)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .data_i(data_i), .row_i(row_i), .col_i(col_i),
    .frame_start_i(frame_start_i), .j0_en_i(j0_en_i), .z0_en_i(z0_en_i),
    .fill_ones_i(fill_ones_i), .trace_i(trace_i), .z0_2_i(z0_2_i), .z0_3_i(z0_3_i),
    .a2_err_cnt_i(a2_err_cnt_i), .a2_err_start_i(a2_err_start_i),
    .data_o(data_o), .no_scr_o(no_scr_o)
  );

  function automatic logic [7:0] tval(int k);
    return 8'(k * 17 + 3);
  endfunction

  typedef struct packed {
    logic       j0, z0, fill;
    logic [7:0] ej0, ez2, ez3;
  } vec_t;

  // Trace entries: T0=03, T1=14, T2=25; Z0 values 5A/C3
  localparam vec_t VECS [7] = '{
    '{1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00},
    '{1'b0, 1'b0, 1'b1, 8'hFF, 8'hFF, 8'hFF},
    '{1'b1, 1'b0, 1'b1, 8'h03, 8'hFF, 8'hFF},
    '{1'b1, 1'b1, 1'b0, 8'h14, 8'h5A, 8'hC3},
    '{1'b1, 1'b1, 1'b1, 8'h25, 8'h5A, 8'hC3},
    '{1'b0, 1'b1, 1'b0, 8'h00, 8'h5A, 8'hC3},
    '{1'b1, 1'b0, 1'b0, 8'h03, 8'h00, 8'h00}
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_frame(logic [7:0] ej0, logic [7:0] ez2, logic [7:0] ez3,
                           bit a2inv, bit pulse, string jtag, string ztag, string atag);
    for (int r = 0; r < FROWS; r++) begin
      for (int c = 0; c < FCOLS; c++) begin
        logic [7:0] din, exp;
        logic       ens;
        string      tag;
        din = 8'(r * 16 + c + 1);
        if (r == 0) begin
          if (c < NUM_STS)                        din = 8'hF6;
          else if (c < 2 * NUM_STS)               din = 8'h28;
          else if (c == 2 * NUM_STS)              din = 8'h77;
          else if (c <= 2 * NUM_STS + 2)          din = 8'h66;
        end
        @(negedge clk);
        row_i          = ROW_W'(r);
        col_i          = COL_W'(c);
        frame_start_i  = (r == 0 && c == 0);
        data_i         = din;
        a2_err_start_i = pulse && r == 1 && c == 5;
        @(posedge clk);
        #1;
        exp = din; ens = 1'b0; tag = "R10";
        if (r == 0 && c == NUM_STS) begin
          exp = a2inv ? ~din : din; tag = atag;
        end else if (r == 0 && c == 2 * NUM_STS) begin
          exp = ej0; ens = 1'b1; tag = jtag;
        end else if (r == 0 && c == 2 * NUM_STS + 1) begin
          exp = ez2; ens = 1'b1; tag = ztag;
        end else if (r == 0 && c == 2 * NUM_STS + 2) begin
          exp = ez3; ens = 1'b1; tag = ztag;
        end
        chk(tag, data_o, exp);
        chk("R7", {7'b0, no_scr_o}, {7'b0, ens});
      end
    end
    @(negedge clk);
    a2_err_start_i = 1'b0;
    frame_start_i  = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < TL; k++) trace_i[k*8 +: 8] = tval(k);
    #12;
    chk("R10", data_o, 8'h00);
    chk("R10", {7'b0, no_scr_o}, 8'h00);
    @(negedge clk);
    rst_ni = 1'b1;

    // Table walk: enable/fill combinations, index clear on disable
    foreach (VECS[i]) begin
      @(negedge clk);
      j0_en_i = VECS[i].j0; z0_en_i = VECS[i].z0; fill_ones_i = VECS[i].fill;
      run_frame(VECS[i].ej0, VECS[i].ez2, VECS[i].ez3, 1'b0, 1'b0,
                (i == 6) ? "R4" : (VECS[i].j0 ? "R1" : "R2"),
                VECS[i].z0 ? "R5" : "R6", "R10");
    end

    // Wrap: index is at 1, run through 15 and back to 0, 1
    for (int f = 0; f < 17; f++) begin
      int k;
      k = (f + 1) % TL;
      run_frame(tval(k), 8'h00, 8'h00, 1'b0, 1'b0, (k == 0) ? "R3" : "R1", "R6", "R10");
    end

    // A2 run of 3 frames; late pulse with new count ignored
    @(negedge clk);
    j0_en_i = 1'b0; z0_en_i = 1'b0; fill_ones_i = 1'b0; a2_err_cnt_i = 5'd2;
    run_frame(8'h00, 8'h00, 8'h00, 1'b0, 1'b1, "R2", "R6", "R8");
    a2_err_cnt_i = 5'd5;
    run_frame(8'h00, 8'h00, 8'h00, 1'b1, 1'b1, "R2", "R6", "R8");
    run_frame(8'h00, 8'h00, 8'h00, 1'b1, 1'b0, "R2", "R6", "R8");
    run_frame(8'h00, 8'h00, 8'h00, 1'b1, 1'b0, "R2", "R6", "R8");
    run_frame(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R2", "R6", "R9");
    run_frame(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R2", "R6", "R9");

    // Maximum run: count 31 gives 32 frames
    a2_err_cnt_i = 5'd31;
    run_frame(8'h00, 8'h00, 8'h00, 1'b0, 1'b1, "R2", "R6", "R8");
    for (int f = 0; f < 32; f++)
      run_frame(8'h00, 8'h00, 8'h00, 1'b1, 1'b0, "R2", "R6", "R8");
    run_frame(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R2", "R6", "R8");

    // Minimum run: count 0 gives 1 frame
    a2_err_cnt_i = 5'd0;
    run_frame(8'h00, 8'h00, 8'h00, 1'b0, 1'b1, "R2", "R6", "R8");
    run_frame(8'h00, 8'h00, 8'h00, 1'b1, 1'b0, "R2", "R6", "R8");
    run_frame(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "R2", "R6", "R8");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule